// File: doc/BRIEF.md
# Clock-Generator Control Register File with Two-Wire Target and Staged Commit

This block is the control port of a line-locked clock generator. It acts as a target on a two-wire I2C bus and holds the generator's configuration and status bytes. The bus lines are oversampled by the system clock, so the same logic works at 100 kHz and 400 kHz bus rates. Each SCL phase must last at least four system clocks. SDA is modelled as an input, an output and an output enable, and the block only ever pulls the line low.

The configuration bytes fall into two groups. The control byte and the output-enable byte take effect as soon as they are written. The loop byte, the two feedback-divider bytes and the input-filter byte are only staged when written. A staged value reaches the parallel configuration outputs only when the commit code 5Ah is written to the commit byte. At that point every staged value moves across in the same clock edge, and a one-cycle restart pulse is issued. The register pointer auto-increments and wraps inside its 16-byte page.

Top module: `clkgen_i2c_regs`

## Requirements
- R1: The target acknowledges a device address whose seven bits equal 0b010011 followed by the level of `addr_sel`. The eighth bit is read/write, with 1 meaning read. Any other address gets no acknowledge, and SDA stays released until the next START.
- R2: After reset, reading 00h returns 41h, 05h returns 01h, 06h returns 00h and 11h returns 01h. At the same point `cfg_ctrl`=41h, `cfg_loop`=00h, `cfg_fbdiv`=000h, `cfg_schmitt_byp`=1 and `cfg_out_en`=0.
- R3: A write to 00h drives `cfg_ctrl` directly. A write to 06h drives `cfg_out_en` from data bit 1. Neither waits for a commit.
- R4: Writes to 01h, 02h, 03h and 05h are visible when those addresses are read back. They leave `cfg_loop`, `cfg_fbdiv` and `cfg_schmitt_byp` unchanged until a commit.
- R5: Writing 5Ah to 08h loads, in one clock edge, `cfg_loop` from 01h, `cfg_fbdiv` from {03h[3:0], 02h} and `cfg_schmitt_byp` from 05h bit 0. The same write pulses `core_restart` for one cycle. Any other value written to 08h has no effect.
- R6: Reading 12h returns `pll_locked` in bit 1, with all other bits 0.
- R7: Reads of 04h, 07h, 08h, 10h and any address without storage return 00h. Writes there, and to 11h and 12h, are acknowledged and change nothing.
- R8: After each data byte the pointer increments in its low four bits only, so 0Fh is followed by 00h. This holds for both reads and writes.
- R9: A random read (address write, repeated START, read) returns the byte at the given address. A read with no address phase continues from the pointer left by the previous access.
- R10: A NACK from the controller ends a read and releases SDA. A START or STOP releases SDA at once. A write byte cut short by STOP or START changes nothing.
- R11: Undefined bits read back as 0. The writable masks are 00h:5Fh, 01h:37h, 02h:FFh, 03h:0Fh, 05h:01h and 06h:02h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_o | output | 1 | Data line output value (always 0) |
| sda_oe | output | 1 | Data line pull-down enable |
| addr_sel | input | 1 | Selects the last device address bit |
| pll_locked | input | 1 | Live loop lock status |
| cfg_ctrl | output | 8 | Active control byte |
| cfg_loop | output | 8 | Active loop byte (pump current, divider) |
| cfg_fbdiv | output | 12 | Active feedback divider word |
| cfg_schmitt_byp | output | 1 | Active input filter bypass |
| cfg_out_en | output | 1 | Active output enable |
| core_restart | output | 1 | One-cycle pulse on a valid commit |

## Verification
The bench checks that staged bytes read back their new values while the active outputs stay at the old ones. It then checks that a wrong commit value moves nothing and that the right one moves every staged field at once. A design that applied staged writes early, or that ignored the code value, would fail on the active outputs. Multi-byte writes and reads are run across the 0Fh boundary, and a design that carried into the upper nibble would write into or read from the next page. A write byte cut short by STOP, a read ended by NACK, and a request to the wrong device address are each checked for a stray register update or a data line still pulled low afterwards.

// File: rtl/clkgen_i2c_pkg.sv
package clkgen_i2c_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_SUB, ST_WR, ST_RD} bus_state_e;

  localparam int PAGE_BITS = 4;
  localparam int FB_W      = 12;
  localparam int HI_W      = FB_W - 8;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_LOOP = 8'h01;
  localparam logic [7:0] A_FBLO = 8'h02;
  localparam logic [7:0] A_FBHI = 8'h03;
  localparam logic [7:0] A_SCHM = 8'h05;
  localparam logic [7:0] A_OEN  = 8'h06;
  localparam logic [7:0] A_CMT  = 8'h08;
  localparam logic [7:0] A_REV  = 8'h11;
  localparam logic [7:0] A_STAT = 8'h12;
  localparam logic [7:0] COMMIT_CODE = 8'h5A;

  // bits that a write may set at each address
  function automatic logic [7:0] wr_mask(input logic [7:0] a);
    case (a)
      A_CTRL:  return 8'h5F;
      A_LOOP:  return 8'h37;
      A_FBLO:  return 8'hFF;
      A_FBHI:  return 8'((1 << HI_W) - 1);
      A_SCHM:  return 8'h01;
      A_OEN:   return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  // pointer step that stays inside its page
  function automatic logic [7:0] next_in_page(input logic [7:0] a);
    return {a[7:PAGE_BITS], a[PAGE_BITS-1:0] + 1'b1};
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_byte_target.sv
module i2c_byte_target
  import clkgen_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       sda_drive_low
);
  bus_state_e state;
  logic [3:0] bitcnt;
  logic       ack_slot, rd_mode, nack, drive;
  logic [7:0] rx;
  logic [6:0] tx;
  logic       byte_done, ack_end;

  assign byte_done     = scl_fall & ~ack_slot & (bitcnt == 4'd8);
  assign ack_end       = scl_fall & ack_slot;
  assign wr_en         = byte_done & (state == ST_WR);
  assign wr_data       = rx;
  assign sda_drive_low = drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; ack_slot <= 1'b0; rd_mode <= 1'b0;
      nack <= 1'b0; drive <= 1'b0; rx <= '0; tx <= '0; ptr <= '0;
    end else if (start_evt) begin
      state <= ST_DEV; bitcnt <= '0; ack_slot <= 1'b0; drive <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE; bitcnt <= '0; ack_slot <= 1'b0; drive <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (!ack_slot && bitcnt != 4'd8) begin
          rx     <= {rx[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (ack_slot && state == ST_RD) begin
          nack <= sda_s;
        end
      end
      if (byte_done) begin
        ack_slot <= 1'b1;
        case (state)
          ST_DEV: if (rx[7:1] == dev_addr) begin
                    drive <= 1'b1; rd_mode <= rx[0];
                  end else state <= ST_IDLE;
          ST_SUB: begin drive <= 1'b1; ptr <= rx; end
          ST_WR:  begin drive <= 1'b1; ptr <= next_in_page(ptr); end
          default: drive <= 1'b0;
        endcase
      end else if (ack_end) begin
        ack_slot <= 1'b0;
        bitcnt   <= '0;
        drive    <= 1'b0;
        if ((state == ST_DEV && rd_mode) || (state == ST_RD && !nack)) begin
          state <= ST_RD;
          tx    <= rd_data[6:0];
          drive <= ~rd_data[7];
          ptr   <= next_in_page(ptr);
        end else if (state == ST_DEV) state <= ST_SUB;
        else if (state == ST_SUB)     state <= ST_WR;
        else if (state == ST_RD)      state <= ST_IDLE;
      end else if (scl_fall && state == ST_RD && bitcnt != 4'd0) begin
        drive <= ~tx[6];
        tx    <= {tx[5:0], 1'b0};
      end
    end
  end

  // R10
  bus_cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_drive_low);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !drive);
  // R1
  ack_only_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && state != ST_RD) |-> ack_slot);
  // R8
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == ST_WR) |=> ptr[7:PAGE_BITS] == $past(ptr[7:PAGE_BITS]));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import clkgen_i2c_pkg::*;
#(
  parameter logic [7:0] CHIP_REV = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      rd_addr,
  input  logic            pll_locked,
  output logic [7:0]      rd_data,
  output logic [7:0]      act_ctrl,
  output logic [7:0]      act_loop,
  output logic [FB_W-1:0] act_fbdiv,
  output logic            act_schm,
  output logic            act_oe,
  output logic            restart
);
  logic [7:0]      ctrl_r, loop_sh;
  logic [FB_W-1:0] fb_sh;
  logic            schm_sh, oe_r;
  logic [7:0]      wr_val;
  logic            commit_hit;

  assign wr_val     = wr_data & wr_mask(wr_addr);
  assign commit_hit = wr_en & (wr_addr == A_CMT) & (wr_data == COMMIT_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= 8'h41; loop_sh <= '0; fb_sh <= '0; schm_sh <= 1'b1; oe_r <= 1'b0;
      act_loop <= '0; act_fbdiv <= '0; act_schm <= 1'b1; restart <= 1'b0;
    end else begin
      restart <= commit_hit;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: ctrl_r <= wr_val;
          A_LOOP: loop_sh <= wr_val;
          A_FBLO: fb_sh[7:0] <= wr_val;
          A_FBHI: fb_sh[FB_W-1:8] <= wr_val[HI_W-1:0];
          A_SCHM: schm_sh <= wr_val[0];
          A_OEN:  oe_r <= wr_val[1];
          default: ;
        endcase
      end
      if (commit_hit) begin
        act_loop  <= loop_sh;
        act_fbdiv <= fb_sh;
        act_schm  <= schm_sh;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_r;
      A_LOOP:  rd_data = loop_sh;
      A_FBLO:  rd_data = fb_sh[7:0];
      A_FBHI:  rd_data = 8'(fb_sh[FB_W-1:8]);
      A_SCHM:  rd_data = {7'b0, schm_sh};
      A_OEN:   rd_data = {6'b0, oe_r, 1'b0};
      A_REV:   rd_data = CHIP_REV;
      A_STAT:  rd_data = {6'b0, pll_locked, 1'b0};
      default: rd_data = 8'h00;
    endcase
  end

  assign act_ctrl = ctrl_r;
  assign act_oe   = oe_r;

  // R4
  staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_hit |=> $stable({act_loop, act_fbdiv, act_schm}));
  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hit |=> (act_fbdiv == $past(fb_sh)) && restart);
  // R3
  oe_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_OEN) |=> act_oe == $past(wr_data[1]));
endmodule

// File: rtl/clkgen_i2c_regs.sv
module clkgen_i2c_regs
  import clkgen_i2c_pkg::*;
#(
  parameter logic [5:0] DEV_BASE    = 6'b010011,
  parameter logic [7:0] CHIP_REV    = 8'h01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_o,
  output logic        sda_oe,
  input  logic        addr_sel,
  input  logic        pll_locked,
  output logic [7:0]  cfg_ctrl,
  output logic [7:0]  cfg_loop,
  output logic [11:0] cfg_fbdiv,
  output logic        cfg_schmitt_byp,
  output logic        cfg_out_en,
  output logic        core_restart
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] ptr, wr_data, rd_data;
  logic wr_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk, .rst_n, .scl_i, .sda_i, .sda_s, .scl_rise, .scl_fall, .start_evt, .stop_evt);

  i2c_byte_target tgt_i (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_evt, .stop_evt,
    .dev_addr({DEV_BASE, addr_sel}), .rd_data, .ptr, .wr_en, .wr_data,
    .sda_drive_low(sda_oe));

  cfg_reg_bank #(.CHIP_REV(CHIP_REV)) bank_i (
    .clk, .rst_n, .wr_en, .wr_addr(ptr), .wr_data, .rd_addr(ptr), .pll_locked,
    .rd_data, .act_ctrl(cfg_ctrl), .act_loop(cfg_loop), .act_fbdiv(cfg_fbdiv),
    .act_schm(cfg_schmitt_byp), .act_oe(cfg_out_en), .restart(core_restart));

  assign sda_o = 1'b0;
endmodule

// File: tb/clkgen_i2c_regs_tb_top.sv
module clkgen_i2c_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0, pll_locked = 1'b0;
  logic sda_o, sda_oe, cfg_schmitt_byp, cfg_out_en, core_restart;
  logic [7:0] cfg_ctrl, cfg_loop;
  logic [11:0] cfg_fbdiv;
  logic sda_bus;
  int n_run = 0, n_fail = 0, restarts = 0;
  localparam int Q = 6, H = 12;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & (sda_oe ? sda_o : 1'b1);

  clkgen_i2c_regs dut_i (.clk, .rst_n, .scl_i(scl_m), .sda_i(sda_bus), .sda_o, .sda_oe,
    .addr_sel, .pll_locked, .cfg_ctrl, .cfg_loop, .cfg_fbdiv, .cfg_schmitt_byp,
    .cfg_out_en, .core_restart);

  always @(posedge clk) if (core_restart) restarts++;

  // {address, write value, expected read-back}
  localparam logic [23:0] VEC [10] = '{
    24'h00FF5F, 24'h01FF37, 24'h02A5A5, 24'h03FF0F, 24'h04FF00,
    24'h05FE00, 24'h06FF02, 24'h073300, 24'h107700, 24'h117701};

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; w(Q); scl_m = 1'b1; w(H); scl_m = 1'b0; w(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(H/2); b = sda_bus; w(H/2); scl_m = 1'b0; w(Q);
  endtask
  task automatic bus_start; sda_m = 1'b0; w(H); scl_m = 1'b0; w(Q); endtask
  task automatic bus_rstart;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0; w(Q);
  endtask
  task automatic bus_stop; sda_m = 1'b0; w(Q); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H); endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = ~a;
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {6'b010011, addr_sel, rd};
  endfunction

  task automatic write_seq(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n);
    logic k;
    bus_start; send_byte(dev(1'b0), k); send_byte(a, k);
    send_byte(d0, k);
    if (n > 1) send_byte(d1, k);
    if (n > 2) send_byte(d2, k);
    bus_stop;
  endtask
  task automatic read_at(input logic [7:0] a, output logic [7:0] b);
    logic k;
    bus_start; send_byte(dev(1'b0), k); send_byte(a, k);
    bus_rstart; send_byte(dev(1'b1), k); recv_byte(1'b0, b); bus_stop;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b, b2;
    logic k;
    w(5); rst_n = 1'b1; w(5);
    // R2 reset state
    chk("R2 cfg_ctrl", cfg_ctrl, 8'h41);
    chk("R2 cfg_loop", cfg_loop, 8'h00);
    chk("R2 cfg_fbdiv", cfg_fbdiv, 12'h000);
    chk("R2 schmitt", cfg_schmitt_byp, 1'b1);
    chk("R2 out_en", cfg_out_en, 1'b0);
    chk("R2 sda_oe", sda_oe, 1'b0);
    read_at(8'h00, b); chk("R2 rd 00h", b, 8'h41);
    read_at(8'h05, b); chk("R2 rd 05h", b, 8'h01);
    read_at(8'h06, b); chk("R2 rd 06h", b, 8'h00);
    read_at(8'h11, b); chk("R2 rd 11h", b, 8'h01);
    // R6 live lock
    pll_locked = 1'b1; read_at(8'h12, b); chk("R6 locked", b, 8'h02);
    pll_locked = 1'b0; read_at(8'h12, b); chk("R6 unlocked", b, 8'h00);
    // R1 device address
    bus_start; send_byte(8'h4E, k); bus_stop; chk("R1 wrong addr nack", k, 1'b0);
    chk("R1 released", sda_oe, 1'b0);
    addr_sel = 1'b1;
    bus_start; send_byte(8'h4E, k); bus_stop; chk("R1 sel=1 ack", k, 1'b1);
    bus_start; send_byte(8'h4C, k); bus_stop; chk("R1 sel=1 other nack", k, 1'b0);
    addr_sel = 1'b0;
    bus_start; send_byte(8'h4C, k); send_byte(8'h12, k); send_byte(8'hFF, k); bus_stop;
    chk("R7 ro write acked", k, 1'b1);
    // R11 R7 table walk
    foreach (VEC[i]) begin
      write_seq(VEC[i][23:16], VEC[i][15:8], 8'h00, 8'h00, 1);
      read_at(VEC[i][23:16], b);
      chk($sformatf("R11/R7 addr %0h", VEC[i][23:16]), b, VEC[i][7:0]);
    end
    chk("R3 ctrl direct", cfg_ctrl, 8'h5F);
    chk("R3 oe direct", cfg_out_en, 1'b1);
    chk("R4 loop held", cfg_loop, 8'h00);
    chk("R4 fbdiv held", cfg_fbdiv, 12'h000);
    chk("R4 schmitt held", cfg_schmitt_byp, 1'b1);
    // R5 wrong code then commit
    write_seq(8'h08, 8'h11, 8'h00, 8'h00, 1);
    chk("R5 bad code fbdiv", cfg_fbdiv, 12'h000);
    chk("R5 bad code restart", restarts, 0);
    read_at(8'h08, b); chk("R7 rd 08h", b, 8'h00);
    write_seq(8'h08, 8'h5A, 8'h00, 8'h00, 1);
    chk("R5 loop", cfg_loop, 8'h37);
    chk("R5 fbdiv", cfg_fbdiv, 12'hFA5);
    chk("R5 schmitt", cfg_schmitt_byp, 1'b0);
    chk("R5 one restart", restarts, 1);
    // R8 write wrap 0Eh,0Fh,00h
    write_seq(8'h0E, 8'h11, 8'h22, 8'h33, 3);
    read_at(8'h00, b); chk("R8 wrap write 00h", b, 8'h13);
    chk("R3 ctrl after wrap", cfg_ctrl, 8'h13);
    // R8 R9 read wrap, then current-address read
    bus_start; send_byte(dev(1'b0), k); send_byte(8'h0F, k);
    bus_rstart; send_byte(dev(1'b1), k);
    recv_byte(1'b1, b); recv_byte(1'b0, b2); bus_stop;
    chk("R9 rd 0Fh", b, 8'h00);
    chk("R8 wrap read 00h", b2, 8'h13);
    chk("R10 nack release", sda_oe, 1'b0);
    bus_start; send_byte(dev(1'b1), k); recv_byte(1'b0, b); bus_stop;
    chk("R9 current addr 01h", b, 8'h37);
    // R10 aborted write byte
    bus_start; send_byte(dev(1'b0), k); send_byte(8'h06, k);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); bus_stop;
    chk("R10 abort released", sda_oe, 1'b0);
    chk("R10 abort oe kept", cfg_out_en, 1'b1);
    read_at(8'h06, b); chk("R10 abort 06h", b, 8'h02);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule